// File: doc/BRIEF.md
# Channel-Status Word Capture

This block gathers the channel-status bit that travels with every received audio subframe and packs successive bits into a 32-bit word. The first bit after a block-start indication fills the most significant position. Each later bit fills the next lower position. The word is assembled in a shadow register. Only when the 32nd bit has arrived is it copied in one step into a holding register, and that holding register is what software reads. Because of this, a read at any moment returns a complete word and never a mix of two blocks. Bits that arrive after the 32nd bit, and bits that arrive before the first block start, are ignored until the next block start.

Each copy into the holding register sets a sticky new-word flag. Software clears this flag either by reading the word or by writing a clear command. A second sticky flag records every accepted frame whose validity bit marks its audio as invalid. Frames enter on a valid/ready stream interface. The block never applies back-pressure: ready is high whenever the block is out of reset, and a frame counts as accepted in every cycle in which valid is high. The read strobe and the clear write are plain control pins.

Top module: `chan_status_capture`

## Requirements
- R1: After a block start, the k-th accepted bit (k = 0 for the bit that carries the block start) is placed at word bit 31-k. The 32nd bit therefore lands in bit 0.
- R2: The readable word changes only at the clock edge that accepts the 32nd bit of a block. It holds its value while a word is still being assembled.
- R3: The new-word flag (`irq_word`) is set at the same clock edge at which the readable word is updated.
- R4: A clear write (`clr_wr`) with `clr_mask` bit 0 set clears the new-word flag. With only bit 1 set, the new-word flag is not changed.
- R5: A read strobe (`rd_stb`) clears the new-word flag.
- R6: When a word completes in the same cycle as a read or a clear of the new-word flag, the flag ends up set.
- R7: Every accepted frame with `in_invalid` high sets the validity flag (`irq_inval`). A clear write with `clr_mask` bit 1 set clears it. A read does not clear it. A set in the same cycle as a clear wins.
- R8: Bits accepted before the first block start, and bits accepted after the 32nd bit of a block without a new block start, change neither the word nor any flag.
- R9: A block start that arrives while a word is partly assembled discards the partial word and restarts at bit 31.
- R10: After reset the readable word is zero, both flags are clear and `in_ready` is high.
- R11: `irq` is high exactly when at least one of the two flags is set.
- R12: While `in_valid` is low, `in_cbit`, `in_blk_start` and `in_invalid` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received frame is presented |
| in_ready | output | 1 | Always high out of reset; no back-pressure |
| in_cbit | input | 1 | Channel-status bit of the frame |
| in_blk_start | input | 1 | Frame is the first of a block |
| in_invalid | input | 1 | Frame's validity bit marks the audio as invalid |
| rd_stb | input | 1 | Software read of the word; clears the new-word flag |
| clr_wr | input | 1 | Software clear write |
| clr_mask | input | 2 | Bit 0 clears the new-word flag, bit 1 clears the validity flag |
| cs_word | output | 32 | Readable channel-status word |
| irq_word | output | 1 | Sticky new-word flag |
| irq_inval | output | 1 | Sticky validity-invalid flag |
| irq | output | 1 | OR of the two flags |

## Verification
Two functions can fall in the same cycle: a flag being set, and software clearing that same flag. For the new-word flag, the bench presents the 32nd bit of a block in the same cycle as both a read strobe and a clear write with mask bit 0. It expects the flag to be set afterwards and the scoreboard to see the new word. For the validity flag, it sends an invalid frame in the same cycle as a clear write with mask bit 1 and expects the flag to remain set. A plain clear or read in a quiet cycle, by contrast, must leave the flag clear.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CS_WORD_W = 32;
  localparam int NUM_FLAGS = 2;
  localparam int FLG_WORD  = 0;
  localparam int FLG_INVAL = 1;
endpackage

// File: rtl/csc_shift.sv
module csc_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         start,
  input  logic         cbit,
  output logic [W-1:0] word_nxt,
  output logic         load
);
  localparam int CNT_W = $clog2(W + 1);
  localparam int IDX_W = $clog2(W);

  logic [W-1:0]     shadow_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx;

  // count == W means idle: waiting for a block start
  assign idx = IDX_W'(W - 1) - cnt_q[IDX_W-1:0];

  always_comb begin
    word_nxt = shadow_q;
    cnt_n    = cnt_q;
    load     = 1'b0;
    if (fire) begin
      if (start) begin
        word_nxt        = '0;
        word_nxt[W-1]   = cbit;
        cnt_n           = CNT_W'(1);
      end else if (cnt_q < CNT_W'(W)) begin
        word_nxt[idx]   = cbit;
        cnt_n           = cnt_q + CNT_W'(1);
        load            = (cnt_q == CNT_W'(W - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cnt_q    <= CNT_W'(W);
    end else begin
      shadow_q <= word_nxt;
      cnt_q    <= cnt_n;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(W)); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fire && start |=> cnt_q == CNT_W'(1)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'(W) && !(fire && start) |=> cnt_q == CNT_W'(W)); // R8
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load); // R3
endmodule

// File: rtl/csc_hold.sv
module csc_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R2
endmodule

// File: rtl/csc_flags.sv
module csc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]); // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !q[i]); // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      q[i] && !clr[i] |=> q[i]); // R7
  end
endmodule

// File: rtl/chan_status_capture.sv
module chan_status_capture #(
  parameter int WORD_W = csc_pkg::CS_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_cbit,
  input  logic              in_blk_start,
  input  logic              in_invalid,
  input  logic              rd_stb,
  input  logic              clr_wr,
  input  logic [1:0]        clr_mask,
  output logic [WORD_W-1:0] cs_word,
  output logic              irq_word,
  output logic              irq_inval,
  output logic              irq
);
  import csc_pkg::*;

  logic                 fire;
  logic                 load;
  logic [WORD_W-1:0]    word_nxt;
  logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_q;

  assign in_ready = rst_n;
  assign fire     = in_valid & in_ready;

  csc_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .fire(fire), .start(in_blk_start),
    .cbit(in_cbit), .word_nxt(word_nxt), .load(load)
  );

  csc_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .d(word_nxt), .q(cs_word)
  );

  always_comb begin
    flg_set            = '0;
    flg_clr            = '0;
    flg_set[FLG_WORD]  = load;
    flg_clr[FLG_WORD]  = rd_stb | (clr_wr & clr_mask[0]);
    flg_set[FLG_INVAL] = fire & in_invalid;
    flg_clr[FLG_INVAL] = clr_wr & clr_mask[1];
  end

  csc_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flg_set), .clr(flg_clr), .q(flg_q)
  );

  assign irq_word  = flg_q[FLG_WORD];
  assign irq_inval = flg_q[FLG_INVAL];
  assign irq       = |flg_q;

  AST_WORD_FLAG_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_word) |-> irq_word); // R3
  AST_INVAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_invalid |=> irq_inval); // R7
  AST_READ_NO_INVAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inval && !(clr_wr && clr_mask[1]) |=> irq_inval); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cs_word)); // R12
endmodule

// File: tb/sim_chan_status_capture.sv
`timescale 1ns/1ps
module sim_chan_status_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_cbit = 0, in_blk_start = 0, in_invalid = 0;
  logic        rd_stb = 0, clr_wr = 0;
  logic [1:0]  clr_mask = 2'b00;
  logic        in_ready, irq_word, irq_inval, irq;
  logic [31:0] cs_word;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] prev_word = 32'h0;

  always #2.5 clk = ~clk;

  chan_status_capture u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cbit(in_cbit), .in_blk_start(in_blk_start), .in_invalid(in_invalid),
    .rd_stb(rd_stb), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .cs_word(cs_word), .irq_word(irq_word), .irq_inval(irq_inval), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic b, input logic s, input logic inv,
                       input logic rd, input logic clr, input logic [1:0] m);
    @(negedge clk);
    in_valid = 1; in_cbit = b; in_blk_start = s; in_invalid = inv;
    rd_stb = rd; clr_wr = clr; clr_mask = m;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_cbit = 0; in_blk_start = 0; in_invalid = 0;
    rd_stb = 0; clr_wr = 0; clr_mask = 2'b00;
  endtask

  task automatic ctl(input logic rd, input logic clr, input logic [1:0] m);
    @(negedge clk);
    in_valid = 0; rd_stb = rd; clr_wr = clr; clr_mask = m;
    idle();
  endtask

  // driver: pushes the expected word, then sends a full block head
  task automatic send_word(input logic [31:0] w);
    exp_q.push_back(w);
    frame(w[31], 1, 0, 0, 0, 2'b00);
    for (int i = 30; i >= 0; i--) frame(w[i], 0, 0, 0, 0, 2'b00);
    idle();
  endtask

  // monitor: every change of the readable word is compared with the queue
  always @(negedge clk) begin
    if (rst_n && cs_word !== prev_word) begin
      if (exp_q.size() == 0) check("R2 unexpected word", cs_word, prev_word);
      else check("R1 word order", cs_word, exp_q.pop_front());
      prev_word = cs_word;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset word", cs_word, 32'h0);
    check("R10 reset flags", {29'h0, irq_word, irq_inval, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R10 ready high", {31'h0, in_ready}, 32'h1);

    // R8: bits before the first block start are ignored
    for (int i = 0; i < 5; i++) frame(1, 0, 0, 0, 0, 2'b00);
    idle();
    check("R8 pre-start word", cs_word, 32'h0);
    check("R8 pre-start flag", {31'h0, irq_word}, 32'h0);

    send_word(32'hA5C3_0F1E);
    check("R1 msb-first", cs_word, 32'hA5C3_0F1E);
    check("R3 new-word flag", {31'h0, irq_word}, 32'h1);
    check("R11 irq or", {31'h0, irq}, 32'h1);

    ctl(0, 1, 2'b10);
    check("R4 mask bit1 keeps word flag", {31'h0, irq_word}, 32'h1);
    ctl(0, 1, 2'b01);
    check("R4 clear write", {31'h0, irq_word}, 32'h0);
    check("R11 irq low", {31'h0, irq}, 32'h0);

    // R8: bits after the 32nd are ignored
    for (int i = 0; i < 10; i++) frame(~cs_word[i], 0, 0, 0, 0, 2'b00);
    idle();
    check("R8 post-word ignored", cs_word, 32'hA5C3_0F1E);
    check("R8 post-word flag", {31'h0, irq_word}, 32'h0);

    // R9 / R2: partial word, then restart
    frame(0, 1, 0, 0, 0, 2'b00);
    for (int i = 0; i < 9; i++) frame(1, 0, 0, 0, 0, 2'b00);
    idle();
    check("R2 partial stable", cs_word, 32'hA5C3_0F1E);
    check("R2 partial flag", {31'h0, irq_word}, 32'h0);
    send_word(32'h8000_0001);
    check("R9 restart word", cs_word, 32'h8000_0001);

    ctl(1, 0, 2'b00);
    check("R5 read clears", {31'h0, irq_word}, 32'h0);

    // R6: completion collides with read and clear
    exp_q.push_back(32'h1234_5678);
    frame(1'b0, 1, 0, 0, 0, 2'b00);
    for (int i = 30; i >= 1; i--) frame(((32'h1234_5678 >> i) & 1) != 0, 0, 0, 0, 0, 2'b00);
    frame(1'b0, 0, 0, 1, 1, 2'b01);
    idle();
    check("R6 load beats clear", {31'h0, irq_word}, 32'h1);
    check("R6 collided word", cs_word, 32'h1234_5678);

    // R7: validity flag
    frame(0, 0, 1, 0, 0, 2'b00);
    idle();
    check("R7 invalid sets", {31'h0, irq_inval}, 32'h1);
    ctl(1, 0, 2'b00);
    check("R7 read keeps inval", {31'h0, irq_inval}, 32'h1);
    ctl(0, 1, 2'b10);
    check("R7 clear inval", {31'h0, irq_inval}, 32'h0);
    frame(0, 0, 1, 0, 1, 2'b10);
    idle();
    check("R7 set beats clear", {31'h0, irq_inval}, 32'h1);
    ctl(0, 1, 2'b11);
    check("R7 both cleared", {30'h0, irq_word, irq_inval}, 32'h0);

    // R12: inputs ignored while valid is low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 0; in_cbit = 1; in_blk_start = i[0]; in_invalid = 1;
    end
    idle();
    check("R12 no inval", {31'h0, irq_inval}, 32'h0);
    check("R12 word kept", cs_word, 32'h1234_5678);
    // a complete block presented with valid low leaves the word alone
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      in_valid = 0; in_cbit = 1; in_blk_start = (i == 0);
    end
    idle();
    check("R12 no load", {31'h0, irq_word}, 32'h0);

    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule